// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block lies on the byte stream between a NAND flash interface and memory. While a 512-byte sector moves through it, one byte per strobe, it builds a 24-bit Hamming-style parity code. The code is made of twelve even/odd parity pairs. Three pairs cover the bit position inside each byte. Nine pairs cover the byte's position inside the sector. Software or a sequencer compares the code with the one kept in the flash spare area. Correction happens outside this block.

A configuration write loads an enable bit and a column-width bit. It can also carry a clear bit, which zeroes the accumulator. Accumulation runs while the block is enabled. When the 512th byte has been taken in, a done flag rises and the code is held until the next clear. The code is shown two ways: as a 32-bit result word, and as three packed bytes ready to be stored.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, done_o is 0 and result_o and code_o are all zero; the block is disabled and in 8-bit column mode.
- R2: A write (cfg_we_i=1) with cfg_clear_i=1 zeroes result_o, the byte count and done_o at that edge. In the same write, cfg_enable_i=1 starts accumulation for the following bytes.
- R3: For each accepted byte, result bits 0, 1 and 2 (even) take the XOR of the data bits whose bit index has bit 0, 1 or 2 clear: masks 0x55, 0x33 and 0x0F. Result bits 16, 17 and 18 (odd) use the complements: 0xAA, 0xCC and 0xF0.
- R4: For index bit j (0..8) of the byte's position, result bit 3+j (even) XORs in the byte's total parity when that index bit is 0. Result bit 19+j (odd) does so when that index bit is 1.
- R5: In 16-bit column mode (cfg_wide_i=1 at the configuration write), the position index is {count[0], count[8:1]}. Index bits 0..7 then come from the 16-bit word number, and index bit 8 comes from the byte lane inside the word.
- R6: done_o rises at the edge that accepts the 512th byte. Bytes strobed while done_o is 1 leave result_o unchanged until a clear.
- R7: A byte strobed while the block is disabled changes neither result_o nor the byte count.
- R8: result_o bits 15:12 and 31:28 always read 0.
- R9: code_o[7:0] equals result_o[7:0], and code_o[15:8] equals result_o[23:16]. code_o[23:16] equals {result_o[27:24], result_o[11:8]}.
- R10: A write with cfg_clear_i=0 keeps the accumulated code and the byte count, and only reloads the enable and width bits. This allows a pause and resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_clear_i | input | 1 | Clear accumulator (with cfg_we_i) |
| cfg_enable_i | input | 1 | Enable accumulation (with cfg_we_i) |
| cfg_wide_i | input | 1 | 16-bit column mode (with cfg_we_i) |
| valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| done_o | output | 1 | Sector complete, code frozen |
| result_o | output | 32 | Even parities in 11:0, odd parities in 27:16 |
| code_o | output | 24 | Packed three-byte code |

## Verification
Single bytes with one bit set, each at a known position, separate the bit-position pairs from the position-index pairs. A wrong mask or a swapped even/odd bit shows up as one flipped result bit. A long pseudo-random byte stream over a full sector checks every index bit against a per-bit model, and the final bytes check the done edge and the freeze. The same stream sent in 16-bit mode yields a different code, which tells the lane-swapped index apart from the plain byte count. Disabled stretches and resumes placed inside a stream show whether bytes are dropped or kept.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int unsigned RESULT_W = 32;
  localparam int unsigned ODD_LSB  = 16;
  localparam int unsigned CODE_W   = 24;

  // Lanes of a DATA_W-bit byte whose index bit j equals sel.
  function automatic logic [7:0] lane_mask(input int unsigned j, input logic sel);
    logic [7:0] m;
    for (int unsigned k = 0; k < 8; k++) begin
      m[k] = (((k >> j) & 1) == 1) == sel;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_col_parity.sv
module ecc_col_parity #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned COL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [COL_W-1:0]  even_o,
  output logic [COL_W-1:0]  odd_o,
  output logic              byte_par_o
);
  import nand_ecc_pkg::*;

  for (genvar j = 0; j < COL_W; j++) begin : g_col
    assign even_o[j] = ^(data_i & lane_mask(j, 1'b0));
    assign odd_o[j]  = ^(data_i & lane_mask(j, 1'b1));
  end

  assign byte_par_o = ^data_i;
endmodule

// File: rtl/ecc_row_parity.sv
module ecc_row_parity #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             byte_par_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] even_o,
  output logic [IDX_W-1:0] odd_o
);
  for (genvar j = 0; j < IDX_W; j++) begin : g_row
    assign even_o[j] = byte_par_i & ~idx_i[j];
    assign odd_o[j]  = byte_par_i &  idx_i[j];
  end
endmodule

// File: rtl/ecc_sector_ctrl.sv
module ecc_sector_ctrl #(
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned IDX_W = $clog2(SECTOR_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_clear_i,
  input  logic             cfg_enable_i,
  input  logic             cfg_wide_i,
  input  logic             valid_i,
  output logic             accept_o,
  output logic             clear_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SECTOR_BYTES - 1);

  logic             en_q, wide_q, done_q;
  logic [IDX_W-1:0] cnt_q;

  assign clear_o  = cfg_we_i & cfg_clear_i;
  assign accept_o = valid_i & en_q & ~done_q & ~cfg_we_i;
  assign idx_o    = wide_q ? {cnt_q[0], cnt_q[IDX_W-1:1]} : cnt_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cfg_we_i) begin
        en_q   <= cfg_enable_i;
        wide_q <= cfg_wide_i;
      end
      if (clear_o) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (accept_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cfg_clear_i,
  input  logic        cfg_enable_i,
  input  logic        cfg_wide_i,
  input  logic        valid_i,
  input  logic [7:0]  data_i,
  output logic        done_o,
  output logic [31:0] result_o,
  output logic [23:0] code_o
);
  import nand_ecc_pkg::*;

  localparam int unsigned COL_W = $clog2(DATA_W);
  localparam int unsigned IDX_W = $clog2(SECTOR_BYTES);
  localparam int unsigned PAR_W = COL_W + IDX_W;

  logic             accept, clear;
  logic [IDX_W-1:0] idx;
  logic [COL_W-1:0] col_e, col_o;
  logic [IDX_W-1:0] row_e, row_o;
  logic             byte_par;
  logic [PAR_W-1:0] even_q, odd_q;

  ecc_sector_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) i_ctrl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_clear_i, .cfg_enable_i, .cfg_wide_i,
    .valid_i, .accept_o(accept), .clear_o(clear), .idx_o(idx), .done_o
  );

  ecc_col_parity #(.DATA_W(DATA_W)) i_col (
    .data_i(data_i[DATA_W-1:0]), .even_o(col_e), .odd_o(col_o), .byte_par_o(byte_par)
  );

  ecc_row_parity #(.IDX_W(IDX_W)) i_row (
    .byte_par_i(byte_par), .idx_i(idx), .even_o(row_e), .odd_o(row_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (clear) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (accept) begin
      even_q <= even_q ^ {row_e, col_e};
      odd_q  <= odd_q  ^ {row_o, col_o};
    end
  end

  always_comb begin
    result_o = '0;
    result_o[PAR_W-1:0]               = even_q;
    result_o[ODD_LSB +: PAR_W]        = odd_q;
  end

  assign code_o = {result_o[27:24], result_o[11:8], result_o[23:16], result_o[7:0]};
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic        cfg_clear_i,
  input logic        valid_i,
  input logic        done_o,
  input logic [31:0] result_o,
  input logic [23:0] code_o
);
  a_r2_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_clear_i) |=> (result_o == 32'h0 && !done_o));

  a_r6_frozen_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(cfg_we_i && cfg_clear_i)) |=> $stable(result_o));

  a_r6_done_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_i));

  a_r7_idle_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !cfg_we_i) |=> $stable(result_o) && $stable(done_o));

  a_r8_gap_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o[15:12] == 4'h0) && (result_o[31:28] == 4'h0));

  a_r9_code_packing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o == {result_o[27:24], result_o[11:8], result_o[23:16], result_o[7:0]});
endmodule

bind nand_ecc_gen nand_ecc_gen_chk i_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_clear_i, .valid_i, .done_o, .result_o, .code_o
);

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_clear = 1'b0, cfg_enable = 1'b0, cfg_wide = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = 8'h0;
  logic        done;
  logic [31:0] result;
  logic [23:0] code;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [11:0] m_even, m_odd;
  int          m_cnt;
  bit          m_en, m_wide;
  logic [7:0]  lfsr;

  always #2.5 clk = ~clk;

  nand_ecc_gen i_nand_ecc_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_clear_i(cfg_clear),
    .cfg_enable_i(cfg_enable), .cfg_wide_i(cfg_wide), .valid_i(valid), .data_i(data),
    .done_o(done), .result_o(result), .code_o(code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_result();
    return {4'h0, m_odd, 4'h0, m_even};
  endfunction

  task automatic check_all(input string req);
    logic [31:0] r;
    r = exp_result();
    chk(req, 64'(result), 64'(r));
    chk({req, "_R9"}, 64'(code), 64'({r[27:24], r[11:8], r[23:16], r[7:0]}));
    chk({req, "_done"}, 64'(done), 64'(m_cnt >= 512));
  endtask

  task automatic cfg(input bit clr, input bit en, input bit wide);
    @(negedge clk);
    cfg_we = 1; cfg_clear = clr; cfg_enable = en; cfg_wide = wide;
    @(negedge clk);
    cfg_we = 0; cfg_clear = 0;
    m_en = en; m_wide = wide;
    if (clr) begin m_even = '0; m_odd = '0; m_cnt = 0; end
  endtask

  task automatic send(input logic [7:0] b);
    logic [8:0] c, idx;
    logic [11:0] a;
    @(negedge clk);
    valid = 1; data = b;
    @(negedge clk);
    valid = 0;
    if (m_en && m_cnt < 512) begin
      c   = 9'(m_cnt);
      idx = m_wide ? {c[0], c[8:1]} : c;
      for (int k = 0; k < 8; k++) begin
        a = {idx, 3'(k)};
        for (int j = 0; j < 12; j++)
          if (a[j]) m_odd[j] ^= b[k]; else m_even[j] ^= b[k];
      end
      m_cnt++;
    end
  endtask

  function automatic logic [7:0] next_rand(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  task automatic t_reset();
    chk("R1_result", 64'(result), 64'h0);
    chk("R1_code", 64'(code), 64'h0);
    chk("R1_done", 64'(done), 64'h0);
    send(8'hFF);  // disabled after reset
    chk("R1_disabled", 64'(result), 64'h0);
  endtask

  task automatic t_bitpos();
    cfg(1, 1, 0);
    check_all("R2_cleared");
    send(8'h01);
    chk("R3_bit0", 64'(result), 64'h0000_0FFF);
    send(8'h80);
    check_all("R3_bit7");
    send(8'h24);
    check_all("R3_mixed");
    send(8'h03);
    check_all("R4_even_par_byte");
  endtask

  task automatic t_index();
    cfg(1, 1, 0);
    lfsr = 8'h5A;
    for (int i = 0; i < 40; i++) begin
      send(lfsr); lfsr = next_rand(lfsr);
    end
    check_all("R4_stream");
    chk("R8_gaps", 64'({result[31:28], result[15:12]}), 64'h0);
  endtask

  task automatic t_pause();
    logic [31:0] held;
    cfg(1, 1, 0);
    send(8'h11); send(8'h22);
    held = result;
    cfg(0, 0, 0);
    send(8'hA5); send(8'h3C);
    chk("R7_ignored", 64'(result), 64'(held));
    cfg(0, 1, 0);
    chk("R10_kept", 64'(result), 64'(held));
    send(8'h44);
    check_all("R10_resume_index");
  endtask

  task automatic t_full();
    logic [31:0] held;
    cfg(1, 1, 0);
    lfsr = 8'hC3;
    for (int i = 0; i < 511; i++) begin
      send(lfsr); lfsr = next_rand(lfsr);
    end
    chk("R6_not_yet", 64'(done), 64'h0);
    send(8'h9E);
    check_all("R6_sector");
    chk("R6_done", 64'(done), 64'h1);
    held = result;
    send(8'h01); send(8'hF0);
    chk("R6_frozen", 64'(result), 64'(held));
    cfg(1, 0, 0);
    check_all("R2_clear_after_done");
  endtask

  task automatic t_wide();
    logic [31:0] narrow;
    cfg(1, 1, 0);
    lfsr = 8'h77;
    for (int i = 0; i < 24; i++) begin send(lfsr); lfsr = next_rand(lfsr); end
    narrow = result;
    cfg(1, 1, 1);
    lfsr = 8'h77;
    for (int i = 0; i < 24; i++) begin send(lfsr); lfsr = next_rand(lfsr); end
    check_all("R5_wide");
    n_chk++;
    if (result === narrow) begin
      n_fail++;
      $display("FAIL R5_differs actual=%0h expected!=%0h", result, narrow);
    end
    send(8'h01);  // count 24: word 12, lane 0
    check_all("R5_lane0");
    send(8'h01);  // count 25: lane 1 -> index bit 8 set
    check_all("R5_lane1");
  endtask

  initial begin
    m_even = '0; m_odd = '0; m_cnt = 0; m_en = 0; m_wide = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bitpos();
    t_index();
    t_pause();
    t_full();
    t_wide();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule